// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block places a 32×32 pointer image over a raster pixel stream on its way to the display. The image lives in an internal bitmap RAM of 1024 words, 16 bits each (2 KB), filled through a simple write port. Every pixel word carries its own direct colour. A set top bit means an opaque RGB555 colour. A clear top bit with nonzero low bits inverts the background. An all-zero word leaves the background untouched.

Software sets the cursor origin through a packed position write and switches the cursor on or off through a control write. Both values land first in shadow registers. With the retrace-sync option set, they are copied into the live registers only on a vertical-blank strobe, so a frame never shows a half-moved cursor. With the option clear, they are copied on the cycle after the write. The display pipeline feeds in the current pixel coordinate and background colour every clock. It gets the composited colour back two clocks later.

Top module: `cursor_overlay`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_rgb` is 0 and the live cursor is disabled. In this state every pixel shows its background after reset releases.
- R2: A write on the bitmap port with `bmp_wdata` at address `row*32 + col` (row in bits 9:5, column in bits 4:0) defines the cursor pixel at column `col` and row `row`.
- R3: A position write places X in `pos_wdata[11:0]` and Y in `pos_wdata[27:16]`. Cursor pixel (col,row) then covers screen pixel (X+col, Y+row).
- R4: A control write sets the enable from `ctl_wdata[0]`. While the live enable is 0, `out_rgb` equals the background for every coordinate.
- R5: A cursor word of 0x0000 passes the background through unchanged.
- R6: A cursor word with bit 15 set is opaque. Bits 14:10, 9:5 and 4:0 are red, green and blue. Each 5-bit channel c is widened to 8 bits as `{c, c[4:2]}`, giving red in `out_rgb[23:16]`, green in 15:8 and blue in 7:0. So 0xFFFF gives 0xFFFFFF and 0x8000 gives 0x000000.
- R7: A cursor word with bit 15 clear and bits 14:0 nonzero gives the bitwise complement of the background, for example 0x7FFF.
- R8: With `retrace_sync` high, a written position takes effect only at the next clock on which `vblank` is high. With `retrace_sync` low, it takes effect one clock after the write.
- R9: The enable follows the same update rule as the position. A position and an enable written before one retrace become visible together at that retrace.
- R10: Coordinates are compared without wrap-around. A cursor whose origin lies near the top of the 12-bit range covers only pixels at or beyond its origin, and never pixels near coordinate 0.
- R11: `out_rgb` reflects the `pix_x`, `pix_y` and `bg_rgb` values sampled two rising edges earlier. After only one edge it still shows the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bmp_we | input | 1 | Bitmap word write strobe |
| bmp_addr | input | 10 | Bitmap word address, row*32+col |
| bmp_wdata | input | 16 | Bitmap word |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control value, bit 0 is enable |
| pos_we | input | 1 | Position write strobe |
| pos_wdata | input | 32 | Packed position, X in 11:0, Y in 27:16 |
| retrace_sync | input | 1 | Defer position and enable updates to vertical blank |
| vblank | input | 1 | Vertical-blank strobe |
| pix_x | input | 12 | Current pixel column |
| pix_y | input | 12 | Current pixel row |
| bg_rgb | input | 24 | Background pixel, 8 bits per channel |
| out_rgb | output | 24 | Composited pixel |

## Verification
The embedded properties watch three things on every clock. They check that the live position and enable stay put while retrace sync is on and no blank strobe arrives. They check that a hit never lies left of or above the cursor origin. They check that misses, transparent words and invert words produce the background or its complement one stage later. Only the bench scenarios can show that the whole picture comes out right. That covers the bitmap address mapping, the RGB555 widening against known colours, and the deferred pair of position and enable appearing at the retrace rather than before it. It also covers the clipped cursor at the coordinate limit, which must stay away from the top-left corner.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int WORD_W = 16;
  localparam int CH_W   = 8;
  localparam int RGB_W  = 3 * CH_W;

  function automatic logic [CH_W-1:0] widen5(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction
endpackage

// File: rtl/cursor_shadow_regs.sv
module cursor_shadow_regs #(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pos_we,
  input  logic [COORD_W-1:0] new_x,
  input  logic [COORD_W-1:0] new_y,
  input  logic               ctl_we,
  input  logic               new_en,
  input  logic               retrace_sync,
  input  logic               vblank,
  output logic [COORD_W-1:0] live_x,
  output logic [COORD_W-1:0] live_y,
  output logic               live_en
);
  logic [COORD_W-1:0] sh_x, sh_y;
  logic               sh_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_x    <= '0;
      sh_y    <= '0;
      sh_en   <= 1'b0;
      live_x  <= '0;
      live_y  <= '0;
      live_en <= 1'b0;
    end else begin
      if (pos_we) begin
        sh_x <= new_x;
        sh_y <= new_y;
      end
      if (ctl_we) sh_en <= new_en;
      if (!retrace_sync || vblank) begin
        live_x  <= sh_x;
        live_y  <= sh_y;
        live_en <= sh_en;
      end
    end
  end

  AST_LIVE_HELD: assert property (@(posedge clk) disable iff (rst)
    (retrace_sync && !vblank) |=> ($stable(live_x) && $stable(live_y) && $stable(live_en))); // R8
  AST_PAIR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!$stable(live_en) && $past(retrace_sync)) |-> $past(vblank)); // R9
endmodule

// File: rtl/cursor_bitmap_ram.sv
module cursor_bitmap_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cursor_locate.sv
module cursor_locate #(
  parameter int COORD_W = 12,
  parameter int SIDE_W  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [COORD_W-1:0]  pix_x,
  input  logic [COORD_W-1:0]  pix_y,
  input  logic [COORD_W-1:0]  org_x,
  input  logic [COORD_W-1:0]  org_y,
  input  logic                enable,
  output logic                hit,
  output logic [2*SIDE_W-1:0] addr
);
  localparam logic [COORD_W:0] SIDE = (COORD_W+1)'(1 << SIDE_W);

  logic [COORD_W:0] dx, dy;
  logic             in_x, in_y;

  // one extra bit keeps the subtraction from wrapping past coordinate 0
  assign dx   = {1'b0, pix_x} - {1'b0, org_x};
  assign dy   = {1'b0, pix_y} - {1'b0, org_y};
  assign in_x = !dx[COORD_W] && (dx < SIDE);
  assign in_y = !dy[COORD_W] && (dy < SIDE);
  assign hit  = enable && in_x && in_y;
  assign addr = {dy[SIDE_W-1:0], dx[SIDE_W-1:0]};

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    hit |-> (pix_x >= org_x && pix_y >= org_y)); // R10
endmodule

// File: rtl/cursor_blend.sv
module cursor_blend
  import cursor_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [RGB_W-1:0]  bg_rgb,
  input  logic [WORD_W-1:0] word,
  output logic [RGB_W-1:0]  out_rgb
);
  logic             hit_q;
  logic [RGB_W-1:0] bg_q;
  logic [RGB_W-1:0] mix;

  always_comb begin
    if (!hit_q || word == '0)
      mix = bg_q;
    else if (word[WORD_W-1])
      mix = {widen5(word[14:10]), widen5(word[9:5]), widen5(word[4:0])};
    else
      mix = ~bg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q   <= 1'b0;
      bg_q    <= '0;
      out_rgb <= '0;
    end else begin
      hit_q   <= hit;
      bg_q    <= bg_rgb;
      out_rgb <= mix;
    end
  end

  AST_MISS_PASS: assert property (@(posedge clk) disable iff (rst)
    !hit_q |=> (out_rgb == $past(bg_q))); // R4
  AST_CLEAR_WORD: assert property (@(posedge clk) disable iff (rst)
    (hit_q && word == '0) |=> (out_rgb == $past(bg_q))); // R5
  AST_INVERT: assert property (@(posedge clk) disable iff (rst)
    (hit_q && !word[WORD_W-1] && word != '0) |=> (out_rgb == ~$past(bg_q))); // R7
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int  COORD_W  = 12,
  parameter int  CUR_SIZE = 32,
  localparam int SIDE_W   = $clog2(CUR_SIZE),
  localparam int ADDR_W   = 2 * SIDE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bmp_we,
  input  logic [ADDR_W-1:0]  bmp_addr,
  input  logic [WORD_W-1:0]  bmp_wdata,
  input  logic               ctl_we,
  input  logic [7:0]         ctl_wdata,
  input  logic               pos_we,
  input  logic [31:0]        pos_wdata,
  input  logic               retrace_sync,
  input  logic               vblank,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [RGB_W-1:0]   bg_rgb,
  output logic [RGB_W-1:0]   out_rgb
);
  localparam int Y_LSB = 16;

  logic [COORD_W-1:0] live_x, live_y;
  logic               live_en;
  logic               hit;
  logic [ADDR_W-1:0]  rd_addr;
  logic [WORD_W-1:0]  rd_word;
  logic               unused_bits;

  assign unused_bits = ^{ctl_wdata[7:1], pos_wdata[Y_LSB-1:COORD_W], pos_wdata[31:Y_LSB+COORD_W]};

  cursor_shadow_regs #(.COORD_W(COORD_W)) u_regs (
    .clk(clk), .rst(rst),
    .pos_we(pos_we),
    .new_x(pos_wdata[COORD_W-1:0]),
    .new_y(pos_wdata[Y_LSB +: COORD_W]),
    .ctl_we(ctl_we), .new_en(ctl_wdata[0]),
    .retrace_sync(retrace_sync), .vblank(vblank),
    .live_x(live_x), .live_y(live_y), .live_en(live_en)
  );

  cursor_locate #(.COORD_W(COORD_W), .SIDE_W(SIDE_W)) u_locate (
    .clk(clk), .rst(rst),
    .pix_x(pix_x), .pix_y(pix_y),
    .org_x(live_x), .org_y(live_y), .enable(live_en),
    .hit(hit), .addr(rd_addr)
  );

  cursor_bitmap_ram #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_ram (
    .clk(clk), .we(bmp_we), .waddr(bmp_addr), .wdata(bmp_wdata),
    .raddr(rd_addr), .rdata(rd_word)
  );

  cursor_blend u_blend (
    .clk(clk), .rst(rst), .hit(hit), .bg_rgb(bg_rgb),
    .word(rd_word), .out_rgb(out_rgb)
  );

  AST_RESET_OUT: assert property (@(posedge clk)
    $past(rst) |-> (out_rgb == '0)); // R1
endmodule

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bmp_we = 1'b0;
  logic [9:0]  bmp_addr = '0;
  logic [15:0] bmp_wdata = '0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic        pos_we = 1'b0;
  logic [31:0] pos_wdata = '0;
  logic        retrace_sync = 1'b0;
  logic        vblank = 1'b0;
  logic [11:0] pix_x = '0;
  logic [11:0] pix_y = '0;
  logic [23:0] bg_rgb = '0;
  logic [23:0] out_rgb;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  logic [15:0] mir [1024];
  bit m_en = 0;
  int m_x = 0, m_y = 0;

  always #5ns clk = ~clk;

  cursor_overlay u_cursor_overlay (
    .clk(clk), .rst(rst), .bmp_we(bmp_we), .bmp_addr(bmp_addr), .bmp_wdata(bmp_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .pos_we(pos_we), .pos_wdata(pos_wdata),
    .retrace_sync(retrace_sync), .vblank(vblank), .pix_x(pix_x), .pix_y(pix_y),
    .bg_rgb(bg_rgb), .out_rgb(out_rgb)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [15:0] pat(int a);
    case (a % 4)
      0: return 16'h0000;
      1: return 16'h8000 | 16'((a * 37) & 16'h7fff);
      2: return 16'(((a * 13) & 16'h7ffe) | 1);
      default: return (a % 8 == 3) ? 16'hFFFF : 16'h8000;
    endcase
  endfunction

  function automatic logic [23:0] bgfn(int x, int y);
    return {8'(x) ^ 8'h5A, 8'(y), 8'(x + y)};
  endfunction

  function automatic logic [7:0] w8(int c);
    return 8'((c << 3) | (c >> 2));
  endfunction

  function automatic logic [23:0] exp_at(int x, int y);
    int c, r;
    logic [15:0] w;
    logic [23:0] bg;
    bg = bgfn(x, y);
    c = x - m_x;
    r = y - m_y;
    if (!m_en || c < 0 || c >= 32 || r < 0 || r >= 32) return bg;
    w = mir[r * 32 + c];
    if (w == 0) return bg;
    if (w[15]) return {w8(int'(w[14:10])), w8(int'(w[9:5])), w8(int'(w[4:0]))};
    return ~bg;
  endfunction

  task automatic check(input logic [23:0] act, input logic [23:0] expv, input string req);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %06h expected %06h", req, act, expv);
    end
  endtask

  task automatic drive_pix(input int x, input int y);
    pix_x  = 12'(x);
    pix_y  = 12'(y);
    bg_rgb = bgfn(x, y);
  endtask

  task automatic chk_pix(input int x, input int y, input string req);
    @(negedge clk);
    drive_pix(x, y);
    @(posedge clk);
    @(posedge clk);
    #1;
    check(out_rgb, exp_at(x, y), req);
  endtask

  task automatic wr_bmp(input int a, input logic [15:0] d);
    @(negedge clk);
    bmp_we = 1'b1; bmp_addr = 10'(a); bmp_wdata = d;
    @(negedge clk);
    bmp_we = 1'b0;
    mir[a] = d;
  endtask

  task automatic wr_pos(input int x, input int y);
    @(negedge clk);
    pos_we = 1'b1; pos_wdata = {4'h0, 12'(y), 4'h0, 12'(x)};
    @(negedge clk);
    pos_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_ctl(input bit en);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = {7'h55, en};
    @(negedge clk);
    ctl_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_vb();
    @(negedge clk);
    vblank = 1'b1;
    @(negedge clk);
    vblank = 1'b0;
  endtask

  initial begin
    logic [23:0] prev;
    drive_pix(101, 51);
    repeat (4) @(posedge clk);
    #1;
    check(out_rgb, 24'h0, "R1 output during reset");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check(out_rgb, 24'h0, "R1 output first clock after reset");
    // live state after reset: disabled, so background passes
    chk_pix(101, 51, "R1 disabled after reset");

    for (int a = 0; a < 1024; a++) wr_bmp(a, pat(a));

    // R4: position set, enable still 0
    wr_pos(100, 50);
    m_x = 100; m_y = 50;
    chk_pix(101, 51, "R4 disabled shows background");
    chk_pix(100, 50, "R4 disabled shows background");
    wr_ctl(1'b1);
    m_en = 1;

    // R2 R3 R5 R6 R7 sweep over cursor plus a border
    for (int y = 48; y < 84; y++)
      for (int x = 96; x < 136; x++)
        chk_pix(x, y, "R2/R3 sweep (R5 R6 R7 by word type)");

    // R6 R7 named colours
    wr_bmp(0, 16'hFFFF);
    wr_bmp(1, 16'h8000);
    wr_bmp(2, 16'h7FFF);
    wr_bmp(3, 16'h0000);
    chk_pix(100, 50, "R6 0xFFFF white");
    check(out_rgb, 24'hFFFFFF, "R6 white literal");
    chk_pix(101, 50, "R6 0x8000 black");
    check(out_rgb, 24'h000000, "R6 black literal");
    chk_pix(102, 50, "R7 0x7FFF invert");
    check(out_rgb, ~bgfn(102, 50), "R7 invert literal");
    chk_pix(103, 50, "R5 0x0000 transparent");
    check(out_rgb, bgfn(103, 50), "R5 transparent literal");

    // R11 latency: two edges
    chk_pix(102, 50, "R11 setup");
    prev = out_rgb;
    @(negedge clk);
    drive_pix(100, 50);
    @(posedge clk); #1;
    check(out_rgb, prev, "R11 unchanged after one edge");
    @(posedge clk); #1;
    check(out_rgb, 24'hFFFFFF, "R11 new value after two edges");

    // R8 deferred position
    @(negedge clk);
    retrace_sync = 1'b1;
    wr_pos(200, 300);
    repeat (3) @(negedge clk);
    chk_pix(101, 51, "R8 old position held before retrace");
    chk_pix(201, 301, "R8 new position not yet shown");
    check(out_rgb, bgfn(201, 301), "R8 new position background literal");
    pulse_vb();
    m_x = 200; m_y = 300;
    chk_pix(201, 301, "R8 new position after retrace");
    chk_pix(101, 51, "R8 old position cleared after retrace");
    check(out_rgb, bgfn(101, 51), "R8 old position background literal");

    // R9 enable and position together
    wr_pos(100, 50);
    wr_ctl(1'b0);
    chk_pix(201, 301, "R9 cursor still visible before retrace");
    chk_pix(101, 51, "R9 new position not shown before retrace");
    pulse_vb();
    m_en = 0; m_x = 100; m_y = 50;
    chk_pix(201, 301, "R9 old position gone after retrace");
    chk_pix(101, 51, "R9 disabled at new position after retrace");
    check(out_rgb, bgfn(101, 51), "R9 disabled literal");

    // R10 clipping at the top of the coordinate range
    @(negedge clk);
    retrace_sync = 1'b0;
    wr_pos(4090, 4090);
    wr_ctl(1'b1);
    m_en = 1; m_x = 4090; m_y = 4090;
    chk_pix(4095, 4095, "R10 visible corner at range end");
    check(out_rgb, {w8(int'(mir[165][14:10])), w8(int'(mir[165][9:5])), w8(int'(mir[165][4:0]))},
          "R10 corner opaque literal");
    chk_pix(3, 3, "R10 no wrap to origin area");
    check(out_rgb, bgfn(3, 3), "R10 no wrap literal");
    chk_pix(0, 0, "R10 no wrap at zero");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule